// File: doc/BRIEF.md
# Quick DMA Trigger and Completion Controller

This block is the control front end for a small group of quick DMA channels. Software binds each channel to one parameter slot and to one 32-bit word inside that slot, then enables the channel. Any later bus write that lands on that exact word raises a transfer request toward a separate transfer engine. No start bit is involved: the request comes from the write itself. The request carries the channel number and the slot number and stays up until the engine acknowledges it.

Writes into the parameter area are passed straight out on a slot-write port, so the parameter memory can sit outside the block. Per channel, the block keeps an enable bit, a secondary-event bit and a missed-event bit. The secondary-event bit marks a transfer that the engine has accepted but not yet finished. The missed-event bit records a trigger that arrived while the channel was still busy. A 64-bit completion-pending vector is set by the engine's completion strobe and cleared by software.

All registers are 32 bits wide. Reads are combinational on the address. Write-only locations read as zero.

Top module: `qdma_ctl`

## Requirements
- R1: After reset, no request is raised, and the enable, secondary, missed and both completion words read 0. Every map register also reads 0.
- R2: Channel c (0..7) has a map register at 0x200 + 4*c. Bits 13:5 hold the slot number and bits 4:2 hold the word index. Every other bit is dropped on write and reads as 0.
- R3: A write with address bits 15:14 = 01 is a parameter write. In the same cycle, slot_we_o goes high, slot_idx_o carries address bits 13:5, slot_word_o carries address bits 4:2, and slot_wdata_o carries the write data.
- R4: A parameter write to slot S, word W starts a request for every channel whose map holds (S, W), whose map is nonzero and whose enable bit is 1. A channel that is disabled, whose map is all zero, or whose map matches only the slot or only the word does not trigger.
- R5: A write of 1s to 0x304 sets enable bits and a write of 1s to 0x308 clears them. Bit c belongs to channel c. The enable state reads at 0x300.
- R6: req_valid_o rises in the cycle after a channel starts waiting. req_valid_o, req_chan_o and req_slot_o then hold steady until the cycle in which req_ack_i is high. req_valid_o is low in the next cycle. Among waiting channels, the lowest number is served first.
- R7: An acknowledge sets the served channel's secondary bit (read at 0x310). A done_i strobe with done_chan_i = c clears bit c, and so does a write of 1 to bit c of 0x310. If a set and a clear hit the same bit together, the bit ends up set.
- R8: A trigger that hits a channel while its request is still waiting or its secondary bit is set raises no new request. Instead it sets the channel's missed bit (read at 0x314). Writing 1s to 0x314 clears missed bits.
- R9: A done_i strobe with code k sets completion bit k. Codes 0..31 read at 0x320 and codes 32..63 read at 0x324, bit k-32. Writing 1s to 0x328 or 0x32C clears the matching low or high bits. When a set and a clear hit the same bit together, the set wins.
- R10: req_slot_o is the slot number the channel's map held when the trigger write occurred. A later rewrite of the map does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access valid this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on the address |
| slot_we_o | output | 1 | Parameter word write strobe |
| slot_idx_o | output | 9 | Parameter slot number |
| slot_word_o | output | 3 | Word index within the slot |
| slot_wdata_o | output | 32 | Parameter write data |
| req_valid_o | output | 1 | Transfer request valid |
| req_chan_o | output | 3 | Requesting channel |
| req_slot_o | output | 9 | Slot to transfer from |
| req_ack_i | input | 1 | Engine accepts the request |
| done_i | input | 1 | Completion strobe |
| done_chan_i | input | 3 | Channel that completed |
| done_code_i | input | 6 | Completion code |

## Verification
The bench runs a behavioural model and compares every cycle. It aims first at two channels mapped to the same word. A design with a faulty arbiter would serve the higher channel first, or would change req_chan_o while a request is still waiting for its acknowledge. It also rewrites a map while a request is still waiting. A design that reads the slot number live at grant time would then send the wrong slot. Retriggers are sent both while a request is waiting and while a secondary bit is set. A design that overlooks either case would raise a second request where it should set the missed bit. The bench also lines up a completion set with a software clear of the same bit, and an acknowledge set with a done clear, in the same cycle. A design that lets the clear win would drop a completion.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CODE_W = 6;
  localparam int CPL_N  = 1 << CODE_W;
  localparam int HALF_N = CPL_N / 2;

  localparam logic [ADDR_W-1:0] MAP_BASE   = 16'h0200;
  localparam logic [ADDR_W-1:0] EN_STAT    = 16'h0300;
  localparam logic [ADDR_W-1:0] EN_SET     = 16'h0304;
  localparam logic [ADDR_W-1:0] EN_CLR     = 16'h0308;
  localparam logic [ADDR_W-1:0] SEC_REG    = 16'h0310;
  localparam logic [ADDR_W-1:0] MISS_REG   = 16'h0314;
  localparam logic [ADDR_W-1:0] CPL_LO     = 16'h0320;
  localparam logic [ADDR_W-1:0] CPL_HI     = 16'h0324;
  localparam logic [ADDR_W-1:0] CPL_CLR_LO = 16'h0328;
  localparam logic [ADDR_W-1:0] CPL_CLR_HI = 16'h032C;
endpackage

// File: rtl/qdma_chan.sv
module qdma_chan #(
  parameter int SLOT_W = 9,
  parameter int WORD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_we_i,
  input  logic [SLOT_W-1:0] map_slot_i,
  input  logic [WORD_W-1:0] map_word_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              sec_clr_i,
  input  logic              miss_clr_i,
  input  logic              par_we_i,
  input  logic [SLOT_W-1:0] par_slot_i,
  input  logic [WORD_W-1:0] par_word_i,
  input  logic              ack_i,
  output logic              en_o,
  output logic              sec_o,
  output logic              miss_o,
  output logic              pend_o,
  output logic [SLOT_W-1:0] map_slot_o,
  output logic [WORD_W-1:0] map_word_o,
  output logic [SLOT_W-1:0] trig_slot_o
);
  logic mapped, hit, busy;

  assign mapped = (map_slot_o != '0) || (map_word_o != '0);
  assign hit    = par_we_i && mapped && en_o &&
                  (par_slot_i == map_slot_o) && (par_word_i == map_word_o);
  assign busy   = pend_o || sec_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_slot_o  <= '0;
      map_word_o  <= '0;
      en_o        <= 1'b0;
      sec_o       <= 1'b0;
      miss_o      <= 1'b0;
      pend_o      <= 1'b0;
      trig_slot_o <= '0;
    end else begin
      if (map_we_i) begin
        map_slot_o <= map_slot_i;
        map_word_o <= map_word_i;
      end
      en_o <= (en_o | en_set_i) & ~en_clr_i;
      // acknowledge outranks any clear
      if (ack_i)           sec_o <= 1'b1;
      else if (sec_clr_i)  sec_o <= 1'b0;
      if (hit && busy)     miss_o <= 1'b1;
      else if (miss_clr_i) miss_o <= 1'b0;
      if (hit && !busy) begin
        pend_o      <= 1'b1;
        trig_slot_o <= map_slot_o;
      end else if (ack_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdma_arb.sv
module qdma_arb #(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              pend_i,
  input  logic [NUM_CH-1:0][SLOT_W-1:0]  slot_i,
  input  logic                           ack_i,
  output logic                           valid_o,
  output logic [CH_W-1:0]                chan_o,
  output logic [SLOT_W-1:0]              slot_o,
  output logic [NUM_CH-1:0]              ack_vec_o
);
  logic [CH_W-1:0] pick;
  logic            fire;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = CH_W'(i);
    end
  end

  assign fire   = valid_o && ack_i;
  assign slot_o = slot_i[chan_o];

  always_comb begin
    ack_vec_o = '0;
    ack_vec_o[chan_o] = fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      chan_o  <= '0;
    end else if (fire) begin
      valid_o <= 1'b0;
    end else if (!valid_o && (pend_i != '0)) begin
      valid_o <= 1'b1;
      chan_o  <= pick;
    end
  end
endmodule

// File: rtl/qdma_cpl.sv
module qdma_cpl #(
  parameter int CODE_W = 6,
  localparam int CPL_N = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CPL_N-1:0]  clr_i,
  output logic [CPL_N-1:0]  pend_o
);
  logic [CPL_N-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[code_i] = done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_vec;
  end
endmodule

// File: rtl/qdma_ctl.sv
module qdma_ctl
  import qdma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  parameter int WORD_W = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int WORD_LSB = 2,
  localparam int SLOT_LSB = WORD_LSB + WORD_W,
  localparam int REGION_LSB = SLOT_LSB + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              slot_we_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [WORD_W-1:0] slot_word_o,
  output logic [DATA_W-1:0] slot_wdata_o,
  output logic              req_valid_o,
  output logic [CH_W-1:0]   req_chan_o,
  output logic [SLOT_W-1:0] req_slot_o,
  input  logic              req_ack_i,
  input  logic              done_i,
  input  logic [CH_W-1:0]   done_chan_i,
  input  logic [CODE_W-1:0] done_code_i
);
  logic wr;
  logic [NUM_CH-1:0] en_q, sec_q, miss_q, pend_q, map_we, ack_vec;
  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot, trig_slot;
  logic [NUM_CH-1:0][WORD_W-1:0] map_word;
  logic [CPL_N-1:0] cpl_q, cpl_clr;

  assign wr           = bus_valid_i && bus_write_i;
  assign slot_we_o    = wr && (bus_addr_i[ADDR_W-1:REGION_LSB] == 1);
  assign slot_idx_o   = bus_addr_i[SLOT_LSB +: SLOT_W];
  assign slot_word_o  = bus_addr_i[WORD_LSB +: WORD_W];
  assign slot_wdata_o = bus_wdata_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign map_we[c] = wr && (bus_addr_i == MAP_BASE + ADDR_W'(4 * c));
      qdma_chan #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_chan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .map_we_i    (map_we[c]),
        .map_slot_i  (bus_wdata_i[SLOT_LSB +: SLOT_W]),
        .map_word_i  (bus_wdata_i[WORD_LSB +: WORD_W]),
        .en_set_i    (wr && bus_addr_i == EN_SET && bus_wdata_i[c]),
        .en_clr_i    (wr && bus_addr_i == EN_CLR && bus_wdata_i[c]),
        .sec_clr_i   ((done_i && done_chan_i == CH_W'(c)) ||
                      (wr && bus_addr_i == SEC_REG && bus_wdata_i[c])),
        .miss_clr_i  (wr && bus_addr_i == MISS_REG && bus_wdata_i[c]),
        .par_we_i    (slot_we_o),
        .par_slot_i  (slot_idx_o),
        .par_word_i  (slot_word_o),
        .ack_i       (ack_vec[c]),
        .en_o        (en_q[c]),
        .sec_o       (sec_q[c]),
        .miss_o      (miss_q[c]),
        .pend_o      (pend_q[c]),
        .map_slot_o  (map_slot[c]),
        .map_word_o  (map_word[c]),
        .trig_slot_o (trig_slot[c])
      );
    end
  endgenerate

  qdma_arb #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_q),
    .slot_i    (trig_slot),
    .ack_i     (req_ack_i),
    .valid_o   (req_valid_o),
    .chan_o    (req_chan_o),
    .slot_o    (req_slot_o),
    .ack_vec_o (ack_vec)
  );

  always_comb begin
    cpl_clr = '0;
    if (wr && bus_addr_i == CPL_CLR_LO) cpl_clr[HALF_N-1:0]     = bus_wdata_i[HALF_N-1:0];
    if (wr && bus_addr_i == CPL_CLR_HI) cpl_clr[CPL_N-1:HALF_N] = bus_wdata_i[HALF_N-1:0];
  end

  qdma_cpl #(.CODE_W(CODE_W)) u_cpl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done_i),
    .code_i (done_code_i),
    .clr_i  (cpl_clr),
    .pend_o (cpl_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      EN_STAT:  bus_rdata_o[NUM_CH-1:0] = en_q;
      SEC_REG:  bus_rdata_o[NUM_CH-1:0] = sec_q;
      MISS_REG: bus_rdata_o[NUM_CH-1:0] = miss_q;
      CPL_LO:   bus_rdata_o = cpl_q[HALF_N-1:0];
      CPL_HI:   bus_rdata_o = cpl_q[CPL_N-1:HALF_N];
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (bus_addr_i == MAP_BASE + ADDR_W'(4 * c)) begin
            bus_rdata_o[SLOT_LSB +: SLOT_W] = map_slot[c];
            bus_rdata_o[WORD_LSB +: WORD_W] = map_word[c];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/qdma_ctl_chk.sv
module qdma_ctl_chk #(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  parameter int CODE_W = 6,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CPL_N = 1 << CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_ack_i,
  input logic [CH_W-1:0]   req_chan_o,
  input logic [SLOT_W-1:0] req_slot_o,
  input logic              done_i,
  input logic [CH_W-1:0]   done_chan_i,
  input logic [CODE_W-1:0] done_code_i,
  input logic [NUM_CH-1:0] sec_q,
  input logic [CPL_N-1:0]  cpl_q
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ack_i |=> req_valid_o && $stable(req_chan_o) && $stable(req_slot_o)); // R6
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ack_i |=> !req_valid_o); // R6
  AST_ACK_SETS_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ack_i |=> sec_q[$past(req_chan_o)]); // R7
  AST_DONE_CLEARS_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !(req_valid_o && req_ack_i && req_chan_o == done_chan_i)
    |=> !sec_q[$past(done_chan_i)]); // R7
  AST_DONE_SETS_CPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cpl_q[$past(done_code_i)]); // R9
endmodule

bind qdma_ctl qdma_ctl_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CODE_W(qdma_pkg::CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ack_i   (req_ack_i),
  .req_chan_o  (req_chan_o),
  .req_slot_o  (req_slot_o),
  .done_i      (done_i),
  .done_chan_i (done_chan_i),
  .done_code_i (done_code_i),
  .sec_q       (sec_q),
  .cpl_q       (cpl_q)
);

// File: tb/qdma_ctl_bench.sv
module qdma_ctl_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic slot_we_o;
  logic [8:0] slot_idx_o;
  logic [2:0] slot_word_o;
  logic [31:0] slot_wdata_o;
  logic req_valid_o;
  logic [2:0] req_chan_o;
  logic [8:0] req_slot_o;
  logic req_ack_i = 1'b0, done_i = 1'b0;
  logic [2:0] done_chan_i = '0;
  logic [5:0] done_code_i = '0;

  int checks = 0, fails = 0, cycles = 0;

  qdma_ctl u_qdma_ctl (.*);

  always #4 clk_i = ~clk_i;

  // reference model state
  logic [8:0] m_mslot[8], m_tslot[8];
  logic [2:0] m_mword[8];
  logic       m_en[8], m_sec[8], m_miss[8], m_pend[8];
  logic       m_busy = 1'b0;
  int         m_cur = 0;
  logic [63:0] m_cpl = '0;

  initial for (int c = 0; c < 8; c++) begin
    m_mslot[c] = '0; m_tslot[c] = '0; m_mword[c] = '0;
    m_en[c] = 0; m_sec[c] = 0; m_miss[c] = 0; m_pend[c] = 0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int c = 0; c < 8; c++) begin
        m_mslot[c] = '0; m_tslot[c] = '0; m_mword[c] = '0;
        m_en[c] = 0; m_sec[c] = 0; m_miss[c] = 0; m_pend[c] = 0;
      end
      m_busy = 0; m_cur = 0; m_cpl = '0;
    end else begin
      automatic logic wr = bus_valid_i && bus_write_i;
      automatic logic par = wr && bus_addr_i[15:14] == 2'b01;
      automatic logic ackf = m_busy && req_ack_i;
      automatic int old_cur = m_cur;
      automatic logic any = 0;
      automatic int low = 0;
      automatic logic [8:0] o_mslot[8];
      automatic logic [2:0] o_mword[8];
      automatic logic o_en[8], o_sec[8], o_pend[8];
      for (int c = 7; c >= 0; c--) begin
        o_mslot[c] = m_mslot[c]; o_mword[c] = m_mword[c];
        o_en[c] = m_en[c]; o_sec[c] = m_sec[c]; o_pend[c] = m_pend[c];
        if (m_pend[c]) begin any = 1; low = c; end
      end
      if (ackf) m_busy = 0;
      else if (!m_busy && any) begin m_busy = 1; m_cur = low; end
      for (int c = 0; c < 8; c++) begin
        automatic logic hit = par && (o_mslot[c] != 0 || o_mword[c] != 0) && o_en[c] &&
                              bus_addr_i[13:5] == o_mslot[c] && bus_addr_i[4:2] == o_mword[c];
        automatic logic ost = o_pend[c] || o_sec[c];
        if (ackf && old_cur == c) m_pend[c] = 0;
        if (hit && !ost) begin m_pend[c] = 1; m_tslot[c] = o_mslot[c]; end
        if (wr && bus_addr_i == 16'h0314 && bus_wdata_i[c]) m_miss[c] = 0;
        if (hit && ost) m_miss[c] = 1;
        if ((done_i && done_chan_i == c) || (wr && bus_addr_i == 16'h0310 && bus_wdata_i[c])) m_sec[c] = 0;
        if (ackf && old_cur == c) m_sec[c] = 1;
        if (wr && bus_addr_i == 16'h0304 && bus_wdata_i[c]) m_en[c] = 1;
        if (wr && bus_addr_i == 16'h0308 && bus_wdata_i[c]) m_en[c] = 0;
        if (wr && bus_addr_i == 16'h0200 + 16'(4 * c)) begin
          m_mslot[c] = bus_wdata_i[13:5]; m_mword[c] = bus_wdata_i[4:2];
        end
      end
      if (wr && bus_addr_i == 16'h0328) m_cpl[31:0]  = m_cpl[31:0]  & ~bus_wdata_i;
      if (wr && bus_addr_i == 16'h032C) m_cpl[63:32] = m_cpl[63:32] & ~bus_wdata_i;
      if (done_i) m_cpl[done_code_i] = 1'b1;
    end
  end

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    logic [31:0] r = '0;
    for (int c = 0; c < 8; c++) begin
      if (a == 16'h0200 + 16'(4 * c)) r = {18'b0, m_mslot[c], m_mword[c], 2'b00};
      if (a == 16'h0300) r[c] = m_en[c];
      if (a == 16'h0310) r[c] = m_sec[c];
      if (a == 16'h0314) r[c] = m_miss[c];
    end
    if (a == 16'h0320) r = m_cpl[31:0];
    if (a == 16'h0324) r = m_cpl[63:32];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 1 ns before the rising edge
  always @(negedge clk_i) begin
    #3;
    cycles++;
    chk("R6 req_valid", 32'(req_valid_o), 32'(m_busy));
    if (m_busy) begin
      chk("R6 req_chan", 32'(req_chan_o), 32'(m_cur));
      chk("R10 req_slot", 32'(req_slot_o), 32'(m_tslot[m_cur]));
    end
    chk("R3 slot_we", 32'(slot_we_o), 32'(bus_valid_i && bus_write_i && bus_addr_i[15:14] == 2'b01));
    if (slot_we_o) begin
      chk("R3 slot_idx", 32'(slot_idx_o), 32'(bus_addr_i[13:5]));
      chk("R3 slot_word", 32'(slot_word_o), 32'(bus_addr_i[4:2]));
      chk("R3 slot_wdata", slot_wdata_o, bus_wdata_i);
    end
  end

  task automatic cyc(logic v, logic w, logic [15:0] a, logic [31:0] d,
                     logic ack, logic dn, logic [2:0] dc, logic [5:0] code);
    @(negedge clk_i);
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d;
    req_ack_i = ack; done_i = dn; done_chan_i = dc; done_code_i = code;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    cyc(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [15:0] a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0);
    #1 chk(tag, bus_rdata_o, exp_rd(a));
  endtask

  task automatic rd_k(logic [15:0] a, logic [31:0] k, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0);
    #1 chk(tag, bus_rdata_o, k);
  endtask

  task automatic ack_next();
    idle(1);
    while (!m_busy) idle(1);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd_k(16'h0300, 0, "R1 en");
    rd_k(16'h0310, 0, "R1 sec");
    rd_k(16'h0314, 0, "R1 miss");
    rd_k(16'h0320, 0, "R1 cpl_lo");
    rd_k(16'h0324, 0, "R1 cpl_hi");
    rd_k(16'h0204, 0, "R1 map1");
    // R2 map fields, stray bits dropped
    wr(16'h0200, 32'hFFFF_FFFF);
    rd_k(16'h0200, 32'h0000_3FFC, "R2 map0 all ones");
    wr(16'h0200, (5 << 5) | (7 << 2));
    wr(16'h020C, (5 << 5) | (7 << 2));
    wr(16'h0204, 32'h0);
    rd_k(16'h020C, 32'h0000_00BC, "R2 map3");
    // R4 disabled channel does not trigger
    wr(16'h40BC, 32'h1111);
    idle(2);
    rd(16'h0314, "R4 no miss when disabled");
    // R5 enable
    wr(16'h0304, 32'h0000_000B);
    rd_k(16'h0300, 32'h0000_000B, "R5 en set");
    wr(16'h0308, 32'h0000_0002);
    rd_k(16'h0300, 32'h0000_0009, "R5 en clr");
    wr(16'h0304, 32'h0000_0002);
    // R4 word mismatch, slot mismatch, map zero
    wr(16'h40B8, 32'h2);
    wr(16'h40DC, 32'h3);
    wr(16'h4000, 32'h4);
    idle(2);
    rd_k(16'h0314, 0, "R4 no trigger on mismatch or zero map");
    // R4/R6 two channels on the same word; R10 remap while waiting
    wr(16'h40BC, 32'hABCD);
    wr(16'h020C, (9 << 5) | (1 << 2));
    ack_next();
    ack_next();
    idle(1);
    rd_k(16'h0310, 32'h0000_0009, "R7 sec after acks");
    // R8 retrigger while sec set
    wr(16'h40BC, 32'h5);
    idle(2);
    rd_k(16'h0314, 32'h0000_0001, "R8 miss on busy sec");
    wr(16'h0314, 32'h1);
    rd_k(16'h0314, 0, "R8 miss clear");
    // R7/R9 done clears sec, sets code 40
    cyc(0, 0, 0, 0, 0, 1, 0, 6'd40);
    idle(1);
    rd_k(16'h0310, 32'h0000_0008, "R7 done clears sec0");
    rd_k(16'h0324, 32'h0000_0100, "R9 code 40 high");
    // R8 retrigger while request still waiting
    wr(16'h40BC, 32'h6);
    wr(16'h40BC, 32'h7);
    idle(1);
    rd_k(16'h0314, 32'h0000_0001, "R8 miss on waiting request");
    // R7 ack and done on same channel same cycle: set wins
    while (!m_busy) idle(1);
    cyc(0, 0, 0, 0, 1, 1, 0, 6'd3);
    idle(1);
    rd_k(16'h0310, 32'h0000_0009, "R7 set wins");
    // R9 set and clear of the same bit together
    cyc(1, 1, 16'h0328, 32'h0000_0008, 0, 1, 1, 6'd3);
    idle(1);
    rd_k(16'h0320, 32'h0000_0008, "R9 set wins");
    wr(16'h0328, 32'h0000_0008);
    wr(16'h032C, 32'h0000_0100);
    rd_k(16'h0320, 0, "R9 clear lo");
    rd_k(16'h0324, 0, "R9 clear hi");
    wr(16'h0310, 32'hFF);
    rd_k(16'h0310, 0, "R7 w1c");
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule